// File: doc/BRIEF.md
# Sticky Status Flags with Alarm Interrupt Steering

This block keeps the sticky status byte of a real-time clock. It holds three flags: an oscillator-halt flag and two alarm-match flags. The oscillator monitor and the two alarm comparators report events as one-cycle pulses. A pulse raises its flag on the next clock edge, and the flag then stays raised until software writes a 0 to its bit position through the register write port. Software can lower a flag but can never raise one.

Two active-low interrupt pins are computed directly from the flags and the enable and steering inputs, with no register in between. The alarm-1 interrupt always goes to pin A. The alarm-2 interrupt goes to pin A when the steering bit is 0 and to pin B when it is 1. The oscillator-halt flag drives neither pin.

Each flag is its own two-state machine:
- States: `FLAG_IDLE` (the flag reads 0) and `FLAG_RAISED` (the flag reads 1).
- Transition `IDLE→RAISED` is taken on a set pulse.
- Transition `RAISED→IDLE` is taken on a clearing write when no set pulse arrives in the same cycle.
- Every other case holds the current state.

The oscillator-halt flag resets into `FLAG_RAISED`. The alarm flags reset into `FLAG_IDLE`.

Top module: `rtc_status_irq`

## Requirements
- R1: After reset, `status_o` reads 0x80 and both interrupt pins read 1.
- R2: Bits 6 down to 2 of `status_o` always read 0.
- R3: A one-cycle pulse on `osc_halt_i`, `alarm1_hit_i` or `alarm2_hit_i` sets bit 7, bit 0 or bit 1 of `status_o` respectively, visible after the next rising clock edge.
- R4: A raised flag stays 1 until a write (`wr_en_i`=1) carries 0 at that flag's bit position. A write that carries 1 there leaves the flag unchanged, and a write clears only the flags whose bits are 0.
- R5: A write can never set a flag. Writing 1 to a flag that reads 0 leaves it at 0.
- R6: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R7: `irq_a_n_o` is 0 exactly when (bit0 and `a1_irq_en_i`) or (bit1 and `a2_irq_en_i` and `a2_to_b_i`=0).
- R8: `irq_b_n_o` is 0 exactly when bit1, `a2_irq_en_i` and `a2_to_b_i` are all 1. With `a2_to_b_i`=1, pin A carries only the alarm-1 interrupt.
- R9: The interrupt pins follow their inputs without a register. A pin returns to 1 in the same cycle its enable drops, or once the flag that drove it is cleared.
- R10: The oscillator-halt flag affects neither interrupt pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_halt_i | input | 1 | Oscillator-halt event pulse |
| alarm1_hit_i | input | 1 | Alarm-1 match pulse |
| alarm2_hit_i | input | 1 | Alarm-2 match pulse |
| a1_irq_en_i | input | 1 | Alarm-1 interrupt enable |
| a2_irq_en_i | input | 1 | Alarm-2 interrupt enable |
| a2_to_b_i | input | 1 | Steers the alarm-2 interrupt to pin B when 1 |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Status write data; a 0 clears the flag at that bit |
| status_o | output | 8 | Status byte |
| irq_a_n_o | output | 1 | Interrupt pin A, active low |
| irq_b_n_o | output | 1 | Interrupt pin B, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit status byte with the oscillator flag at bit 7. With these values every flag, the reserved bits, and both steering settings are observable at the ports.

The walked vectors cover the following cases:
- a set pulse and a clearing write arriving together;
- a write of all ones that tries to set flags;
- a partial clear that lowers one alarm flag and leaves the other;
- an enable dropping while its flag stays raised.

A reset applied in the middle of the run confirms that the oscillator flag comes back raised.

// File: rtl/rtc_status_pkg.sv
package rtc_status_pkg;
    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    typedef enum logic {
        ROUTE_SHARED = 1'b0,
        ROUTE_SPLIT  = 1'b1
    } a2_route_e;

    localparam int unsigned NUM_ALARMS = 2;
endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell
    import rtc_status_pkg::*;
#(
    parameter bit RESET_RAISED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic raised_o
);
    localparam flag_state_e RESET_STATE = RESET_RAISED ? FLAG_RAISED : FLAG_IDLE;

    flag_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_nx;
    end

    // next state: set pulse wins over a clearing write
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (set_i)           state_nx = FLAG_RAISED;
            FLAG_RAISED: if (clr_i && !set_i) state_nx = FLAG_IDLE;
            default:                          state_nx = RESET_STATE;
        endcase
    end

    // outputs
    always_comb begin
        raised_o = (state_q == FLAG_RAISED);
    end

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> raised_o);
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raised_o && !clr_i) |=> raised_o);
    a_r5_no_write_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!raised_o && !set_i) |=> !raised_o);
endmodule

// File: rtl/rtc_irq_route.sv
module rtc_irq_route
    import rtc_status_pkg::*;
(
    input  logic a1_flag_i,
    input  logic a2_flag_i,
    input  logic a1_en_i,
    input  logic a2_en_i,
    input  logic route_i,
    output logic irq_a_n_o,
    output logic irq_b_n_o
);
    a2_route_e route;
    logic a1_req, a2_req;

    always_comb begin
        route  = a2_route_e'(route_i);
        a1_req = a1_flag_i & a1_en_i;
        a2_req = a2_flag_i & a2_en_i;
        unique case (route)
            ROUTE_SHARED: begin
                irq_a_n_o = !(a1_req || a2_req);
                irq_b_n_o = 1'b1;
            end
            ROUTE_SPLIT: begin
                irq_a_n_o = !a1_req;
                irq_b_n_o = !a2_req;
            end
            default: begin
                irq_a_n_o = 1'b1;
                irq_b_n_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/rtc_status_irq.sv
module rtc_status_irq
    import rtc_status_pkg::*;
#(
    parameter int unsigned STATUS_W = 8,
    parameter int unsigned OSC_BIT  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                osc_halt_i,
    input  logic                alarm1_hit_i,
    input  logic                alarm2_hit_i,
    input  logic                a1_irq_en_i,
    input  logic                a2_irq_en_i,
    input  logic                a2_to_b_i,
    input  logic                wr_en_i,
    input  logic [STATUS_W-1:0] wr_data_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                irq_a_n_o,
    output logic                irq_b_n_o
);
    logic [NUM_ALARMS-1:0] alarm_hit;
    logic [NUM_ALARMS-1:0] alarm_flag;
    logic                  osc_flag;

    assign alarm_hit = {alarm2_hit_i, alarm1_hit_i};

    // alarm flag n lives at status bit n
    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
        rtc_flag_cell #(.RESET_RAISED(1'b0)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (alarm_hit[g]),
            .clr_i    (wr_en_i && !wr_data_i[g]),
            .raised_o (alarm_flag[g])
        );
    end

    rtc_flag_cell #(.RESET_RAISED(1'b1)) u_osc_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (osc_halt_i),
        .clr_i    (wr_en_i && !wr_data_i[OSC_BIT]),
        .raised_o (osc_flag)
    );

    always_comb begin
        status_o                   = '0;
        status_o[NUM_ALARMS-1:0]   = alarm_flag;
        status_o[OSC_BIT]          = osc_flag;
    end

    rtc_irq_route u_route (
        .a1_flag_i (alarm_flag[0]),
        .a2_flag_i (alarm_flag[1]),
        .a1_en_i   (a1_irq_en_i),
        .a2_en_i   (a2_irq_en_i),
        .route_i   (a2_to_b_i),
        .irq_a_n_o (irq_a_n_o),
        .irq_b_n_o (irq_b_n_o)
    );

    a_r8_b_idle_when_shared: assert property (@(posedge clk) disable iff (!rst_n)
        !a2_to_b_i |-> irq_b_n_o);
    a_r7_alarm1_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && a1_irq_en_i) |-> !irq_a_n_o);
    a_r3_alarm2_sets: assert property (@(posedge clk) disable iff (!rst_n)
        alarm2_hit_i |=> status_o[1]);
    a_r10_osc_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1:0] == 2'b00) |-> (irq_a_n_o && irq_b_n_o));
endmodule

// File: tb/rtc_status_irq_tb.sv
module rtc_status_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc, a1, a2, a1en, a2en, rt, wr;
    logic [7:0] wd;
    logic [7:0] st;
    logic       ia, ib;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    rtc_status_irq u_dut (
        .clk(clk), .rst_n(rst_n), .osc_halt_i(osc), .alarm1_hit_i(a1),
        .alarm2_hit_i(a2), .a1_irq_en_i(a1en), .a2_irq_en_i(a2en),
        .a2_to_b_i(rt), .wr_en_i(wr), .wr_data_i(wd), .status_o(st),
        .irq_a_n_o(ia), .irq_b_n_o(ib)
    );

    // {req[3:0], osc,a1,a2,a1en,a2en,rt,wr, wd[7:0], exp_st[7:0], exp_a, exp_b}
    localparam int NV = 14;
    localparam logic [28:0] VEC [NV] = '{
        {4'd4,  7'b0000001, 8'h7F, 8'h00, 2'b11},
        {4'd3,  7'b0100000, 8'h00, 8'h01, 2'b11},
        {4'd7,  7'b0001000, 8'h00, 8'h01, 2'b01},
        {4'd4,  7'b0001001, 8'hFF, 8'h01, 2'b01},
        {4'd9,  7'b0001001, 8'hFE, 8'h00, 2'b11},
        {4'd5,  7'b0000001, 8'h03, 8'h00, 2'b11},
        {4'd7,  7'b0010100, 8'h00, 8'h02, 2'b01},
        {4'd8,  7'b0000110, 8'h00, 8'h02, 2'b10},
        {4'd9,  7'b0000010, 8'h00, 8'h02, 2'b11},
        {4'd6,  7'b0100111, 8'hFE, 8'h03, 2'b10},
        {4'd6,  7'b1000001, 8'h00, 8'h80, 2'b11},
        {4'd10, 7'b0001100, 8'h00, 8'h80, 2'b11},
        {4'd8,  7'b0111111, 8'h7C, 8'h03, 2'b00},
        {4'd4,  7'b0001111, 8'hFD, 8'h01, 2'b01}
    };

    task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got st=%h a=%b b=%b expected st=%h a=%b b=%b",
                     req, got[9:2], got[1], got[0], exp[9:2], exp[1], exp[0]);
        end
    endtask

    task automatic idle_inputs();
        {osc, a1, a2, a1en, a2en, rt, wr} = '0;
        wd = 8'h00;
    endtask

    initial begin
        #150000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        #23;
        check("R1 reset value", {st, ia, ib}, {8'h80, 2'b11});
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {st, ia, ib}, {8'h80, 2'b11});

        for (int i = 0; i < NV; i++) begin
            {osc, a1, a2, a1en, a2en, rt, wr} = VEC[i][24:18];
            wd = VEC[i][17:10];
            @(posedge clk);
            #2;
            check($sformatf("R%0d vector %0d", VEC[i][28:25], i),
                  {st, ia, ib}, VEC[i][9:0]);
            check("R2 reserved bits", {st[6:2], 5'b0}, 10'b0);
            @(negedge clk);
        end

        // R9: enable drop releases pin within the same cycle (flag bit0 still 1)
        idle_inputs();
        a1en = 1'b1;
        #1;
        check("R9 enable on", {st, ia, ib}, {8'h01, 2'b01});
        a1en = 1'b0;
        #1;
        check("R9 enable drop", {st, ia, ib}, {8'h01, 2'b11});

        // R1: mid-run reset brings oscillator flag back raised, alarms clear
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R1 mid-run reset", {st, ia, ib}, {8'h80, 2'b11});
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 held after reset", {st, ia, ib}, {8'h80, 2'b11});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule